// File: doc/BRIEF.md
# Delayed-Branch Program Counter Sequencer

This block produces the fetch address for a simple in-order stream of 16-bit instructions. On every cycle that carries a valid instruction, it takes a decoded instruction class, a branch target and two compare operands. From these it picks the next fetch address.

Conditions come from a single sticky flag. Only the two compare classes write the flag. All other classes leave it as it is.

An unconditional jump is always delayed: the instruction that follows it, called the slot, still executes before fetch moves to the target. Conditional branches come in two forms:
- The plain form redirects on the next cycle.
- The delayed form lets the slot run first.

A branch found in a slot is illegal. The block flags it on a one-cycle error output and ignores it, and the earlier redirect still takes effect.

Top module: `pcseq_top`

## Requirements
- R1: While `rst` is high at a clock edge, `fetch_addr` loads `rst_vector`, and `flag`, `slot_err` and the pending-slot state are all cleared. A delayed branch in flight at reset is therefore forgotten.
- R2: The `in_class` codes are:
  - 0: plain/arithmetic
  - 1: signed greater-or-equal compare
  - 2: equality compare
  - 3: unconditional jump
  - 4: branch-if-true
  - 5: branch-if-false
  - 6: delayed branch-if-true
  - 7: delayed branch-if-false

  A valid class 0, 1 or 2 with no slot pending advances `fetch_addr` by 2 on the next edge.
- R3: A valid jump advances `fetch_addr` by 2. The next valid instruction (the slot) then sets `fetch_addr` to the jump target.
- R4: A valid plain branch-if-true with `flag`=1, or branch-if-false with `flag`=0, loads `in_target` into `fetch_addr` on the next edge.
- R5: A delayed conditional branch whose condition holds advances by 2 first. The following valid slot instruction then loads the saved target.
- R6: A conditional branch of either form whose condition fails advances by 2 and arms no slot.
- R7: Class 1 sets `flag` when `opa` >= `opb` as two's-complement numbers, and clears it otherwise.
- R8: Class 2 sets `flag` when `opa` equals `opb`, and clears it otherwise.
- R9: Classes other than 1 and 2 leave `flag` unchanged.
- R10: A valid branch (classes 3 to 7) arriving in a slot makes `slot_err` 1 for exactly the following cycle. The branch itself is ignored, and `fetch_addr` goes to the earlier saved target.
- R11: When `in_valid` is low, `fetch_addr`, `flag` and any pending slot keep their values, and `slot_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_vector | input | ADDR_W | Address loaded on reset |
| in_valid | input | 1 | An instruction is present this cycle |
| in_class | input | 3 | Decoded instruction class |
| in_target | input | ADDR_W | Branch target address |
| opa | input | DATA_W | First compare operand |
| opb | input | DATA_W | Second compare operand |
| fetch_addr | output | ADDR_W | Next fetch address (registered) |
| flag | output | 1 | Current condition flag (registered) |
| slot_err | output | 1 | One-cycle pulse after a branch in a slot |

## Verification
The stream is built so that each branch form meets both flag values. A plain branch with a true condition must redirect at once, while its delayed twin must show one +2 step before the target; a mix-up between the two forms therefore shows up as an address one step off.

The compare operands are chosen to tell signed from unsigned ordering (a negative value against a positive one) and to test the equal boundary, where greater-or-equal must still set the flag. A compare placed in a slot shows that flag update and redirect happen together.

Idle cycles placed between a jump and its slot show that the pending redirect survives gaps. Illegal branches in slots, one of them a jump, show that the first target wins. A reset with a slot armed shows that the pending state is dropped.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  typedef enum logic [2:0] {
    CLS_PLAIN  = 3'd0,
    CLS_CMP_GE = 3'd1,
    CLS_CMP_EQ = 3'd2,
    CLS_JMP    = 3'd3,
    CLS_BT     = 3'd4,
    CLS_BF     = 3'd5,
    CLS_BT_D   = 3'd6,
    CLS_BF_D   = 3'd7
  } instr_cls_e;

  localparam int unsigned CLS_W = 3;
endpackage

// File: rtl/pcseq_decide.sv
module pcseq_decide
  import pcseq_pkg::*;
(
  input  instr_cls_e cls,
  input  logic       flag,
  output logic       is_branch,
  output logic       take,
  output logic       delayed
);
  always_comb begin
    is_branch = 1'b0;
    take      = 1'b0;
    delayed   = 1'b0;
    unique case (cls)
      CLS_JMP:  begin is_branch = 1'b1; take = 1'b1;  delayed = 1'b1; end
      CLS_BT:   begin is_branch = 1'b1; take = flag;  end
      CLS_BF:   begin is_branch = 1'b1; take = !flag; end
      CLS_BT_D: begin is_branch = 1'b1; take = flag;  delayed = 1'b1; end
      CLS_BF_D: begin is_branch = 1'b1; take = !flag; delayed = 1'b1; end
      default:  ;
    endcase
  end
endmodule

// File: rtl/pcseq_flag.sv
module pcseq_flag
  import pcseq_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_en,
  input  instr_cls_e        cls,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              flag_q
);
  logic ge_res;
  logic eq_res;

  assign ge_res = $signed(opa) >= $signed(opb);
  assign eq_res = (opa == opb);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else if (upd_en) begin
      if (cls == CLS_CMP_GE)      flag_q <= ge_res;
      else if (cls == CLS_CMP_EQ) flag_q <= eq_res;
    end
  end
endmodule

// File: rtl/pcseq_slot.sv
module pcseq_slot #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              consume,
  input  logic [ADDR_W-1:0] tgt_in,
  output logic              pend_q,
  output logic [ADDR_W-1:0] tgt_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      tgt_q  <= '0;
    end else if (consume) begin
      pend_q <= 1'b0;
    end else if (arm) begin
      pend_q <= 1'b1;
      tgt_q  <= tgt_in;
    end
  end
endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
  import pcseq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned INSTR_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rst_vector,
  input  logic              in_valid,
  input  logic [2:0]        in_class,
  input  logic [ADDR_W-1:0] in_target,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              flag,
  output logic              slot_err
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

  instr_cls_e        cls;
  logic              is_branch, take, delayed;
  logic              slot_pend;
  logic [ADDR_W-1:0] slot_tgt;
  logic              arm, consume, illegal;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic              err_q;

  assign cls = instr_cls_e'(in_class);

  pcseq_decide u_decide (
    .cls       (cls),
    .flag      (flag),
    .is_branch (is_branch),
    .take      (take),
    .delayed   (delayed)
  );

  pcseq_flag #(.DATA_W(DATA_W)) u_flag (
    .clk    (clk),
    .rst    (rst),
    .upd_en (in_valid),
    .cls    (cls),
    .opa    (opa),
    .opb    (opb),
    .flag_q (flag)
  );

  assign consume = in_valid && slot_pend;
  assign illegal = consume && is_branch;
  assign arm     = in_valid && !slot_pend && take && delayed;

  pcseq_slot #(.ADDR_W(ADDR_W)) u_slot (
    .clk     (clk),
    .rst     (rst),
    .arm     (arm),
    .consume (consume),
    .tgt_in  (in_target),
    .pend_q  (slot_pend),
    .tgt_q   (slot_tgt)
  );

  always_comb begin
    if (!in_valid)            pc_d = pc_q;
    else if (slot_pend)       pc_d = slot_tgt;
    else if (take && !delayed) pc_d = in_target;
    else                      pc_d = pc_q + STEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= rst_vector;
      err_q <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      err_q <= illegal;
    end
  end

  assign fetch_addr = pc_q;
  assign slot_err   = err_q;
endmodule

// File: rtl/pcseq_chk.sv
module pcseq_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [2:0]        in_class,
  input logic [DATA_W-1:0] opa,
  input logic [DATA_W-1:0] opb,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              flag,
  input logic              slot_err,
  input logic              slot_pend
);
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(fetch_addr) && $stable(flag) && !slot_err);

  // R9
  flag_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_class != 3'd1 && in_class != 3'd2) |=> $stable(flag));

  // R8
  eq_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_class == 3'd2) |=> flag == $past(opa == opb));

  // R7
  ge_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_class == 3'd1) |=> flag == $past($signed(opa) >= $signed(opb)));

  // R10
  slot_err_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && slot_pend && in_class >= 3'd3) |=> slot_err);

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !slot_pend && in_class <= 3'd2) |=> fetch_addr == $past(fetch_addr) + ADDR_W'(2));
endmodule

bind pcseq_top pcseq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_class   (in_class),
  .opa        (opa),
  .opb        (opb),
  .fetch_addr (fetch_addr),
  .flag       (flag),
  .slot_err   (slot_err),
  .slot_pend  (slot_pend)
);

// File: tb/tb_pcseq_top.sv
module tb_pcseq_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] rst_vector = 32'h0000_1000;
  logic        in_valid = 1'b0;
  logic [2:0]  in_class = 3'd0;
  logic [31:0] in_target = '0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic [31:0] fetch_addr;
  logic        flag;
  logic        slot_err;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pcseq_top dut (
    .clk(clk), .rst(rst), .rst_vector(rst_vector), .in_valid(in_valid),
    .in_class(in_class), .in_target(in_target), .opa(opa), .opb(opb),
    .fetch_addr(fetch_addr), .flag(flag), .slot_err(slot_err)
  );

  typedef struct packed {
    logic        v;
    logic [2:0]  cls;
    logic [31:0] tgt;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] addr;
    logic        fl;
    logic        er;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd0, 32'h0,     32'd0,         32'd0, 32'h1002, 1'b0, 1'b0, 8'd2},  // R2 plain
    '{1'b1, 3'd1, 32'h0,     32'd5,         32'd3, 32'h1004, 1'b1, 1'b0, 8'd7},  // R7 5>=3
    '{1'b1, 3'd4, 32'h2000,  32'd0,         32'd0, 32'h2000, 1'b1, 1'b0, 8'd4},  // R4 BT taken
    '{1'b1, 3'd5, 32'h3000,  32'd0,         32'd0, 32'h2002, 1'b1, 1'b0, 8'd6},  // R6 BF not taken
    '{1'b1, 3'd1, 32'h0,     32'hFFFF_FFFF, 32'd1, 32'h2004, 1'b0, 1'b0, 8'd7},  // R7 signed -1<1
    '{1'b1, 3'd0, 32'h0,     32'd9,         32'd9, 32'h2006, 1'b0, 1'b0, 8'd9},  // R9 add keeps 0
    '{1'b1, 3'd7, 32'h4000,  32'd0,         32'd0, 32'h2008, 1'b0, 1'b0, 8'd5},  // R5 BF_D taken
    '{1'b1, 3'd0, 32'h0,     32'd0,         32'd0, 32'h4000, 1'b0, 1'b0, 8'd5},  // R5 slot -> target
    '{1'b1, 3'd2, 32'h0,     32'd7,         32'd7, 32'h4002, 1'b1, 1'b0, 8'd8},  // R8 equal
    '{1'b1, 3'd3, 32'h5000,  32'd0,         32'd0, 32'h4004, 1'b1, 1'b0, 8'd3},  // R3 jump
    '{1'b1, 3'd2, 32'h0,     32'd1,         32'd2, 32'h5000, 1'b0, 1'b0, 8'd3},  // R3 slot cmp, R8 unequal
    '{1'b1, 3'd6, 32'h6000,  32'd0,         32'd0, 32'h5002, 1'b0, 1'b0, 8'd6},  // R6 BT_D not taken
    '{1'b0, 3'd3, 32'h9999,  32'd4,         32'd4, 32'h5002, 1'b0, 1'b0, 8'd11}, // R11 idle
    '{1'b1, 3'd1, 32'h0,     32'd3,         32'd3, 32'h5004, 1'b1, 1'b0, 8'd7},  // R7 equal bound
    '{1'b1, 3'd0, 32'h0,     32'd1,         32'd0, 32'h5006, 1'b1, 1'b0, 8'd9},  // R9 add keeps 1
    '{1'b1, 3'd3, 32'h7000,  32'd0,         32'd0, 32'h5008, 1'b1, 1'b0, 8'd3},  // R3 jump
    '{1'b0, 3'd0, 32'h0,     32'd0,         32'd0, 32'h5008, 1'b1, 1'b0, 8'd11}, // R11 gap in slot
    '{1'b1, 3'd4, 32'h8000,  32'd0,         32'd0, 32'h7000, 1'b1, 1'b1, 8'd10}, // R10 BT in slot
    '{1'b1, 3'd0, 32'h0,     32'd0,         32'd0, 32'h7002, 1'b1, 1'b0, 8'd10}, // R10 pulse ends
    '{1'b1, 3'd6, 32'h9000,  32'd0,         32'd0, 32'h7004, 1'b1, 1'b0, 8'd5},  // R5 BT_D taken
    '{1'b1, 3'd3, 32'hA000,  32'd0,         32'd0, 32'h9000, 1'b1, 1'b1, 8'd10}, // R10 jump in slot
    '{1'b1, 3'd0, 32'h0,     32'd0,         32'd0, 32'h9002, 1'b1, 1'b0, 8'd10}  // R10 ignored jump
  };

  task automatic check(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [2:0] c, input logic [31:0] t,
                       input logic [31:0] a, input logic [31:0] b);
    in_valid = v; in_class = c; in_target = t; opa = a; opb = b;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    @(negedge clk); @(negedge clk);
    // R1 reset state
    check("reset addr", 1, fetch_addr, 32'h1000);
    check("reset flag", 1, {31'd0, flag}, 32'd0);
    check("reset err", 1, {31'd0, slot_err}, 32'd0);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].v, VECS[i].cls, VECS[i].tgt, VECS[i].a, VECS[i].b);
      check("addr", VECS[i].req, fetch_addr, VECS[i].addr);
      check("flag", VECS[i].req, {31'd0, flag}, {31'd0, VECS[i].fl});
      check("err", VECS[i].req, {31'd0, slot_err}, {31'd0, VECS[i].er});
    end
    // R1 reset while a jump slot is pending
    drive(1'b1, 3'd3, 32'hB000, 32'd0, 32'd0);
    check("jump before reset", 3, fetch_addr, 32'h9004);
    rst = 1'b1; rst_vector = 32'h0000_0100;
    drive(1'b1, 3'd0, 32'h0, 32'd0, 32'd0);
    check("reset vector", 1, fetch_addr, 32'h100);
    check("reset flag", 1, {31'd0, flag}, 32'd0);
    rst = 1'b0;
    drive(1'b1, 3'd0, 32'h0, 32'd0, 32'd0);
    check("slot dropped", 1, fetch_addr, 32'h102);
    // R4 plain BF taken with flag 0
    drive(1'b1, 3'd5, 32'hC000, 32'd0, 32'd0);
    check("BF taken", 4, fetch_addr, 32'hC000);
    // R6 plain BT not taken with flag 0
    drive(1'b1, 3'd4, 32'hD000, 32'd0, 32'd0);
    check("BT not taken", 6, fetch_addr, 32'hC002);
    // R7 signed: 1 >= -1 sets flag
    drive(1'b1, 3'd1, 32'h0, 32'd1, 32'hFFFF_FFFF);
    check("ge signed", 7, {31'd0, flag}, 32'd1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule